// File: doc/BRIEF.md
# Output-Compare PWM Waveform Generator

This block produces a fixed-frequency pulse-width-modulated waveform from a free-running 16-bit counter and one compare target. It never compares a wrapping period counter against a duty value. Every time the counter reaches the target, the output pin takes a level that was preset beforehand. The target then moves forward by the on delay or the off delay, and the preset level flips for the next match. Because the target advances by whole segment lengths, the high time of the waveform is the on delay in ticks and the low time is the off delay in ticks.

The counter advances only on a prescaler tick supplied from outside. In a typical system this tick is the oscillator divided by eight. With a 2 µs tick and both delays at 125, the output is a 2 kHz square wave at 50% duty. The two 8-bit delay inputs can change at any time. The block samples each delay at the match that starts the segment the delay controls. A compare-event strobe marks every edge of the output, and the live counter value is brought out for observation.

Top module: `ocpwm_gen`

## Requirements
- R1: While reset is asserted, `pwm_o` is 0, `match_o` is 0 and `count_o` is 0.
- R2: `count_o` increases by exactly one in the clock after each cycle with `tick_i` high, holds its value when `tick_i` is low, and wraps from 65535 to 0.
- R3: A match is a cycle in which `tick_i` is high and the counter equals the compare target. In the clock that follows a match, `pwm_o` takes the preset level and `match_o` is high for exactly that one cycle.
- R4: The preset level is high after reset and is inverted after every match, so matches drive the pin high, then low, then high, and so on.
- R5: A match that drives the pin high moves the target forward by `on_dly_i`, and one that drives it low moves the target forward by `off_dly_i`. The resulting high segment lasts `on_dly_i` ticks and the low segment lasts `off_dly_i` ticks, measured in `count_o` between consecutive `match_o` pulses.
- R6: After reset the first compare target is the reset counter value (0) plus the default delay of 125. The first `match_o` therefore shows `count_o` = 126 and `pwm_o` = 1.
- R7: A delay input is sampled only at the match that starts its segment. A change in mid-segment leaves the running segment unaltered and takes effect from the next segment of that polarity.
- R8: The target addition wraps modulo 65536, so a target that passes 65535 is still matched after the counter rolls over.
- R9: `pwm_o` and the internal preset level change only in the clock after a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaler tick; the counter advances once per cycle in which it is high |
| on_dly_i | input | 8 | Length of the high segment in ticks |
| off_dly_i | input | 8 | Length of the low segment in ticks |
| pwm_o | output | 1 | PWM waveform |
| match_o | output | 1 | One-cycle strobe in the clock after each compare match |
| count_o | output | 16 | Live value of the free-running counter |

## Verification
Assertions check the cycle-level rules on every clock. They cover the counter step and hold, the rule that the pin takes the preset level after a match, the flip of the preset level, the advance of the target by the delay for the current polarity, and the quiet pin and held target between matches. The bench scenarios show what no single-cycle property can. These are the segment lengths seen at the ports, the value of the first target after reset, the effect of a delay change in mid-segment arriving one segment later, and a match found only after the counter rolls over.

// File: rtl/ocpwm_pkg.sv
package ocpwm_pkg;

  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } lvl_e;

  localparam int unsigned DEF_CNT_W    = 16;
  localparam int unsigned DEF_DLY_W    = 8;
  localparam int unsigned DEF_INIT_DLY = 125;

endpackage

// File: rtl/ocpwm_timebase.sv
module ocpwm_timebase #(
  parameter int unsigned CNT_W = ocpwm_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;

  // R2: one step per tick, wrapping naturally
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));

  // R2: no tick, no movement
  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));

endmodule

// File: rtl/ocpwm_compare.sv
module ocpwm_compare #(
  parameter int unsigned CNT_W    = ocpwm_pkg::DEF_CNT_W,
  parameter int unsigned DLY_W    = ocpwm_pkg::DEF_DLY_W,
  parameter int unsigned INIT_DLY = ocpwm_pkg::DEF_INIT_DLY
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  ocpwm_pkg::lvl_e  lvl_i,
  input  logic [DLY_W-1:0] on_dly_i,
  input  logic [DLY_W-1:0] off_dly_i,
  output logic             hit_o
);

  import ocpwm_pkg::*;

  // Next target: the base advanced by an unsigned delay, modulo 2^CNT_W.
  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] base,
                                               input logic [DLY_W-1:0] dly);
    return base + CNT_W'(dly);
  endfunction

  localparam logic [CNT_W-1:0] TGT_RST = CNT_W'(INIT_DLY);

  logic [CNT_W-1:0] tgt_q;
  logic [DLY_W-1:0] dly_sel;
  logic             hit;

  // The preset level says which segment the coming match starts.
  assign dly_sel = (lvl_i == LVL_HIGH) ? on_dly_i : off_dly_i;
  assign hit     = tick_i && (cnt_i == tgt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= advance('0, DLY_W'(TGT_RST));
    end else if (hit) begin
      tgt_q <= advance(tgt_q, dly_sel);
    end
  end

  assign hit_o = hit;

  // R5: a high-going match moves the target by the on delay
  p_adv_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && lvl_i == LVL_HIGH) |=> tgt_q == CNT_W'($past(tgt_q) + CNT_W'($past(on_dly_i))));

  // R5: a low-going match moves the target by the off delay
  p_adv_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && lvl_i == LVL_LOW) |=> tgt_q == CNT_W'($past(tgt_q) + CNT_W'($past(off_dly_i))));

  // R7: delays do not reach the target between matches
  p_tgt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(tgt_q));

endmodule

// File: rtl/ocpwm_level.sv
module ocpwm_level (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit_i,
  output ocpwm_pkg::lvl_e lvl_o,
  output logic            pwm_o,
  output logic            strobe_o
);

  import ocpwm_pkg::*;

  lvl_e lvl_q;
  logic pwm_q;
  logic strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q    <= LVL_HIGH;
      pwm_q    <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= hit_i;
      if (hit_i) begin
        pwm_q <= (lvl_q == LVL_HIGH);
        lvl_q <= (lvl_q == LVL_HIGH) ? LVL_LOW : LVL_HIGH;
      end
    end
  end

  assign lvl_o    = lvl_q;
  assign pwm_o    = pwm_q;
  assign strobe_o = strobe_q;

  // R3: the pin takes the level preset before the match
  p_pin_preset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> pwm_q == ($past(lvl_q) == LVL_HIGH));

  // R3: the strobe follows each match and nothing else
  p_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> strobe_q);
  p_strobe_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_i |=> !strobe_q);

  // R4: the preset level flips at every match
  p_level_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> lvl_q != $past(lvl_q));

  // R9: between matches the pin and preset hold
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_i |=> ($stable(pwm_q) && $stable(lvl_q)));

endmodule

// File: rtl/ocpwm_gen.sv
module ocpwm_gen #(
  parameter int unsigned CNT_W    = ocpwm_pkg::DEF_CNT_W,
  parameter int unsigned DLY_W    = ocpwm_pkg::DEF_DLY_W,
  parameter int unsigned INIT_DLY = ocpwm_pkg::DEF_INIT_DLY
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [DLY_W-1:0] on_dly_i,
  input  logic [DLY_W-1:0] off_dly_i,
  output logic             pwm_o,
  output logic             match_o,
  output logic [CNT_W-1:0] count_o
);

  import ocpwm_pkg::*;

  logic [CNT_W-1:0] cnt_w;
  logic             hit_w;
  lvl_e             lvl_w;

  ocpwm_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .cnt_o  (cnt_w)
  );

  ocpwm_compare #(
    .CNT_W    (CNT_W),
    .DLY_W    (DLY_W),
    .INIT_DLY (INIT_DLY)
  ) u_compare (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .cnt_i     (cnt_w),
    .lvl_i     (lvl_w),
    .on_dly_i  (on_dly_i),
    .off_dly_i (off_dly_i),
    .hit_o     (hit_w)
  );

  ocpwm_level u_level (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_i    (hit_w),
    .lvl_o    (lvl_w),
    .pwm_o    (pwm_o),
    .strobe_o (match_o)
  );

  assign count_o = cnt_w;

  // R3: a strobe always follows a cycle where a tick moved the counter
  p_strobe_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> $past(tick_i));

endmodule

// File: tb/ocpwm_gen_tb.sv
module ocpwm_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic [7:0]  on_dly_i = 8'd125;
  logic [7:0]  off_dly_i = 8'd125;
  logic        pwm_o;
  logic        match_o;
  logic [15:0] count_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ocpwm_gen u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .on_dly_i  (on_dly_i),
    .off_dly_i (off_dly_i),
    .pwm_o     (pwm_o),
    .match_o   (match_o),
    .count_o   (count_o)
  );

  // Reference state built from the requirements
  logic [15:0] m_cnt, m_tgt;
  logic        m_lvl, m_pwm, m_match;

  function automatic logic [15:0] ref_step(input logic [15:0] v);
    return v + 16'd1;
  endfunction

  function automatic logic [15:0] ref_target(input logic [15:0] t, input logic [7:0] d);
    logic [16:0] s;
    s = {1'b0, t} + {9'd0, d};
    return s[15:0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 16'd0; m_tgt <= 16'd125; m_lvl <= 1'b1;
      m_pwm <= 1'b0;  m_match <= 1'b0;
    end else begin
      m_match <= tick_i && (m_cnt == m_tgt);
      if (tick_i && (m_cnt == m_tgt)) begin
        m_pwm <= m_lvl;
        m_lvl <= ~m_lvl;
        m_tgt <= ref_target(m_tgt, m_lvl ? on_dly_i : off_dly_i);
      end
      if (tick_i) m_cnt <= ref_step(m_cnt);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Segment tracking at the ports
  logic [15:0] edge_cnt;
  logic        have_edge, prev_high, first_seen, wrap_seen;
  logic [7:0]  on_at, off_at;

  task automatic step();
    logic [15:0] len;
    @(negedge clk);
    chk(count_o == m_cnt, "R2 count", count_o, m_cnt);
    chk(pwm_o == m_pwm, "R3/R9 pwm", pwm_o, m_pwm);
    chk(match_o == m_match, "R3 strobe", match_o, m_match);
    if (match_o) begin
      if (!first_seen) begin
        chk(count_o == 16'd126, "R6 first target", count_o, 126);
        chk(pwm_o == 1'b1, "R4 first level high", pwm_o, 1);
        first_seen = 1'b1;
      end
      if (have_edge) begin
        len = count_o - edge_cnt;
        chk(len == (prev_high ? on_at : off_at), "R5/R7 segment length",
            len, prev_high ? on_at : off_at);
        chk(pwm_o != prev_high, "R4 alternation", pwm_o, !prev_high);
        if (count_o < edge_cnt) wrap_seen = 1'b1;
      end
      edge_cnt  = count_o;
      prev_high = pwm_o;
      on_at     = on_dly_i;
      off_at    = off_dly_i;
      have_edge = 1'b1;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick_i = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(pwm_o == 1'b0 && match_o == 1'b0 && count_o == 16'd0, "R1 reset state",
          {pwm_o, match_o, count_o}, 0);
    end
    have_edge = 1'b0; first_seen = 1'b0;
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    wrap_seen = 1'b0;
    do_reset();

    // Directed: default delays, full-rate ticks, a few segments
    for (int i = 0; i < 600; i++) begin
      step();
      tick_i = 1'b1;
    end

    // R7: change on delay just after a rising match; current segment unchanged
    on_dly_i = 8'd20; off_dly_i = 8'd9;
    for (int i = 0; i < 400; i++) step();
    begin
      bit done = 1'b0;
      for (int i = 0; i < 400 && !done; i++) begin
        step();
        if (match_o && pwm_o) begin on_dly_i = 8'd7; done = 1'b1; end
      end
    end
    for (int i = 0; i < 200; i++) step();

    // Random ticks and delays (never zero)
    for (int i = 0; i < 20000; i++) begin
      step();
      tick_i = ($urandom % 3) != 0;
      if (($urandom % 60) == 0) on_dly_i  = 8'(1 + ($urandom % 40));
      if (($urandom % 60) == 0) off_dly_i = 8'(1 + ($urandom % 40));
    end

    // Reset mid-run, then check the first target again with sparse ticks
    do_reset();
    for (int i = 0; i < 800; i++) begin
      step();
      tick_i = ($urandom % 2) != 0;
    end

    // R8: long delays at full rate until the target wraps past 65535
    on_dly_i = 8'd255; off_dly_i = 8'd254;
    for (int i = 0; i < 68000; i++) begin
      step();
      tick_i = 1'b1;
    end
    chk(wrap_seen, "R8 match after rollover", wrap_seen, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule